// File: doc/BRIEF.md
# Bit-Serial HDLC Transmitter with Byte-Demand Pacing

This block turns a stream of user payload bytes into a bit-serial HDLC line signal. A line-rate bit-enable advances it one bit at a time. Between frames it sends the flag 0x7E over and over. Payload bytes come from the terminal equipment over an 8-bit parallel bus. A one-cycle demand strobe tells the equipment that a byte is being taken. After five ones in a row in the payload, the block inserts a zero. Each inserted zero holds the serial stream back by one bit time. The next demand is held back by the same amount, so the byte rate drops below line rate divided by eight whenever stuffing takes place.

A send-message input controls framing. While it is high, the block opens a frame and keeps demanding bytes. When it falls, no further bytes are demanded. Every byte already demanded is sent in full, followed by a closing flag. The equipment places the new byte on the bus right after the demand. The block latches the bus half a byte-time later, on the fourth bit-enable after the demand. Each byte is fetched one byte ahead into a holding register.

Control is a four-state machine:
- IDLE sends idle flags. At the end of each flag it either stays in IDLE or moves to OPEN when send-message is high. The move to OPEN issues the first demand.
- OPEN sends the opening flag. At its end the machine moves to DATA and loads the first byte. It also issues the next demand if send-message is still high.
- DATA sends payload bits and stuffed zeros. At each byte end it stays in DATA if the holding register is full, reloading and demanding again while send-message is high. If the holding register is empty it moves to CLOSE.
- CLOSE sends the closing flag. At its end it moves to OPEN if send-message is high, otherwise to IDLE.

Top module: `hdlc_byte_demand_tx`

## Requirements
- R1: During reset, line_bit and byte_req are 0. After reset, the serial output is a continuous run of flags, each sent MSB first as 0,1,1,1,1,1,1,0.
- R2: byte_req is asserted only after a clock edge at which send_msg was high. While send_msg stays low, no byte is demanded and only flags are sent.
- R3: When send_msg is high at the end of a flag, the next flag on the line is the opening flag. The first demand of the frame is issued at the start of that opening flag.
- R4: Each payload byte is sent LSB first. The line_bit output changes only at clock edges where bit_en is high. Once zeros are removed and flags are stripped, the decoded frames equal the demanded bytes, in order.
- R5: pay_byte is captured at the fourth bit_en edge after the edge that raised byte_req. Values on the bus before or after that point have no effect.
- R6: After five consecutive payload ones, a zero is inserted, even when the run crosses a byte boundary or ends on a byte's last bit. The run count restarts after any zero or inserted zero. Flags are never stuffed, so the line never carries more than six ones in a row.
- R7: Within a frame, the second demand follows the first by 8 bit_en edges. Each later demand follows the previous one by 8 plus the number of zeros inserted into the byte that started at the previous demand.
- R8: byte_req is a single-cycle strobe: it is never high for two cycles in a row.
- R9: After send_msg falls, every byte already demanded is sent whole and then a closing flag follows. Each frame holds exactly as many bytes as were demanded for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit-enable, one pulse per line bit time |
| send_msg | input | 1 | High while the equipment has payload to send |
| pay_byte | input | DW | Payload byte bus from the terminal equipment |
| byte_req | output | 1 | One-cycle demand strobe for the next payload byte |
| line_bit | output | 1 | Serial HDLC output, updated on each bit_en |

## Verification
Some faults show at the ports within a handful of bit times. A run counter off by one gives a seven-one run, or a zero in the wrong place, which breaks the next decoded byte. A capture point off by one bit-enable latches stale or scrambled bus data, and that byte decodes wrong. A miscounted byte end changes the spacing of the next demand by at least one bit time. A wrong choice at the end of a frame adds or drops a byte, and the byte count fails as soon as the closing flag is decoded. The bench decodes the serial stream on its own, measures the bit-enables between demands against a stuffing model, and drives the bus with valid data only up to the expected capture point.

// File: rtl/hdlc_txd_pkg.sv
package hdlc_txd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_DATA  = 2'd2,
        ST_CLOSE = 2'd3
    } txd_state_e;

endpackage

// File: rtl/hdlc_txd_fsm.sv
module hdlc_txd_fsm
    import hdlc_txd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       send_msg,
    input  logic       flag_last,
    input  logic       byte_fin,
    input  logic       hold_vld,
    output txd_state_e state,
    output logic       load_byte,
    output logic       req_fire
);

    txd_state_e st_q;
    txd_state_e st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state selection
    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (flag_last && send_msg) st_d = ST_OPEN;
                end
                ST_OPEN: begin
                    if (flag_last) st_d = ST_DATA;
                end
                ST_DATA: begin
                    if (byte_fin && !hold_vld) st_d = ST_CLOSE;
                end
                ST_CLOSE: begin
                    if (flag_last) st_d = send_msg ? ST_OPEN : ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs: byte load and demand
    always_comb begin
        load_byte = 1'b0;
        req_fire  = 1'b0;
        if (bit_en) begin
            unique case (st_q)
                ST_IDLE, ST_CLOSE: begin
                    req_fire = flag_last && send_msg;
                end
                ST_OPEN: begin
                    load_byte = flag_last;
                    req_fire  = flag_last && send_msg;
                end
                ST_DATA: begin
                    load_byte = byte_fin && hold_vld;
                    req_fire  = byte_fin && hold_vld && send_msg;
                end
                default: begin
                    load_byte = 1'b0;
                    req_fire  = 1'b0;
                end
            endcase
        end
    end

    assign state = st_q;

    AST_OPEN_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPEN && bit_en && flag_last) |-> hold_vld); // R3

    AST_CLOSE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CLOSE && $past(st_q) != ST_CLOSE) |-> ($past(st_q) == ST_DATA)); // R9

endmodule

// File: rtl/hdlc_txd_flag.sv
module hdlc_txd_flag #(
    parameter int              DW       = 8,
    parameter logic [DW-1:0]   FLAG_PAT = 8'h7E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic active,
    output logic flag_bit,
    output logic flag_last
);

    localparam int            IW       = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DW - 1);

    logic [IW-1:0] fidx_q;

    // position inside the flag; parked at zero while payload is sent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fidx_q <= '0;
        end else if (!active) begin
            fidx_q <= '0;
        end else if (bit_en) begin
            fidx_q <= (fidx_q == LAST_IDX) ? '0 : fidx_q + 1'b1;
        end
    end

    always_comb begin
        flag_bit  = FLAG_PAT[LAST_IDX - fidx_q];
        flag_last = (fidx_q == LAST_IDX);
    end

endmodule

// File: rtl/hdlc_txd_stuff.sv
module hdlc_txd_stuff #(
    parameter int DW        = 8,
    parameter int STUFF_RUN = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          in_data,
    input  logic          load_byte,
    input  logic [DW-1:0] load_val,
    output logic          data_bit,
    output logic          byte_fin
);

    localparam int            IW       = (DW > 1) ? $clog2(DW) : 1;
    localparam int            OW       = $clog2(STUFF_RUN + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(DW - 1);
    localparam logic [OW-1:0] RUN_MAX  = OW'(STUFF_RUN);

    logic [DW-1:0] sh_q;
    logic [IW-1:0] idx_q;
    logic [OW-1:0] ones_q;
    logic [OW-1:0] ones_d;
    logic          done_q;
    logic          stuff_now;
    logic          cur_bit;

    always_comb begin
        cur_bit   = sh_q[idx_q];
        stuff_now = (ones_q == RUN_MAX);
        data_bit  = stuff_now ? 1'b0 : cur_bit;
        if (stuff_now) begin
            ones_d = '0;
        end else if (cur_bit) begin
            ones_d = ones_q + 1'b1;
        end else begin
            ones_d = '0;
        end
        // a byte ends after its last data bit, or after the zero it still owes
        if (stuff_now) begin
            byte_fin = bit_en && in_data && done_q;
        end else begin
            byte_fin = bit_en && in_data && (idx_q == LAST_IDX) && (ones_d != RUN_MAX);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            idx_q  <= '0;
            ones_q <= '0;
            done_q <= 1'b0;
        end else if (bit_en) begin
            ones_q <= in_data ? ones_d : '0;
            if (load_byte) begin
                sh_q   <= load_val;
                idx_q  <= '0;
                done_q <= 1'b0;
            end else if (in_data && !stuff_now && !done_q) begin
                if (idx_q == LAST_IDX) begin
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    AST_STUFF_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && in_data && ones_q == RUN_MAX) |=> (ones_q == '0)); // R6

    AST_FLAG_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !in_data) |=> (ones_q == '0)); // R6

    AST_OWED_ZERO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && done_q) |-> (ones_q == RUN_MAX)); // R6

endmodule

// File: rtl/hdlc_txd_fetch.sv
module hdlc_txd_fetch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          req_fire,
    input  logic          load_byte,
    input  logic [DW-1:0] pay_byte,
    output logic          byte_req,
    output logic [DW-1:0] hold_q,
    output logic          hold_vld
);

    localparam int            HALF = (DW / 2 > 0) ? DW / 2 : 1;
    localparam int            CW   = $clog2(HALF + 1);
    localparam logic [CW-1:0] HALF_C = CW'(HALF);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    logic [CW-1:0] cap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_req <= 1'b0;
            cap_cnt  <= '0;
            hold_q   <= '0;
            hold_vld <= 1'b0;
        end else begin
            byte_req <= req_fire;
            if (bit_en) begin
                if (req_fire) begin
                    cap_cnt <= HALF_C;
                end else if (cap_cnt != '0) begin
                    cap_cnt <= cap_cnt - 1'b1;
                end
            end
            if (load_byte) begin
                hold_vld <= 1'b0;
            end
            if (bit_en && cap_cnt == ONE_C) begin
                hold_q   <= pay_byte;
                hold_vld <= 1'b1;
            end
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |=> !byte_req); // R8

    AST_CAPTURE_INTO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cap_cnt == ONE_C) |-> !hold_vld); // R5

    AST_NO_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |-> (cap_cnt == '0)); // R7

endmodule

// File: rtl/hdlc_byte_demand_tx.sv
module hdlc_byte_demand_tx
    import hdlc_txd_pkg::*;
#(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] FLAG_PAT  = 8'h7E,
    parameter int            STUFF_RUN = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          send_msg,
    input  logic [DW-1:0] pay_byte,
    output logic          byte_req,
    output logic          line_bit
);

    txd_state_e    state;
    logic          in_data;
    logic          flag_bit;
    logic          flag_last;
    logic          data_bit;
    logic          byte_fin;
    logic          load_byte;
    logic          req_fire;
    logic          hold_vld;
    logic [DW-1:0] hold_q;

    assign in_data = (state == ST_DATA);

    hdlc_txd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .send_msg  (send_msg),
        .flag_last (flag_last),
        .byte_fin  (byte_fin),
        .hold_vld  (hold_vld),
        .state     (state),
        .load_byte (load_byte),
        .req_fire  (req_fire)
    );

    hdlc_txd_flag #(.DW(DW), .FLAG_PAT(FLAG_PAT)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .active    (!in_data),
        .flag_bit  (flag_bit),
        .flag_last (flag_last)
    );

    hdlc_txd_stuff #(.DW(DW), .STUFF_RUN(STUFF_RUN)) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .in_data   (in_data),
        .load_byte (load_byte),
        .load_val  (hold_q),
        .data_bit  (data_bit),
        .byte_fin  (byte_fin)
    );

    hdlc_txd_fetch #(.DW(DW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .req_fire  (req_fire),
        .load_byte (load_byte),
        .pay_byte  (pay_byte),
        .byte_req  (byte_req),
        .hold_q    (hold_q),
        .hold_vld  (hold_vld)
    );

    // serial output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_bit <= 1'b0;
        end else if (bit_en) begin
            line_bit <= in_data ? data_bit : flag_bit;
        end
    end

    AST_REQ_WITH_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> $past(send_msg)); // R2

    AST_LINE_MOVES_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(line_bit)); // R4

    AST_REQ_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> $past(bit_en)); // R7

endmodule

// File: tb/tb_hdlc_byte_demand_tx.sv
`timescale 1ns/1ps
module tb_hdlc_byte_demand_tx;

    localparam int DW    = 8;
    localparam int HALF  = DW / 2;
    localparam int NFR   = 30;
    localparam int LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic          send_msg = 1'b0;
    logic [DW-1:0] pay_byte = '0;
    logic          byte_req;
    logic          line_bit;

    hdlc_byte_demand_tx dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .send_msg (send_msg),
        .pay_byte (pay_byte),
        .byte_req (byte_req),
        .line_bit (line_bit)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // stimulus bookkeeping
    logic       be_drv = 1'b0;
    logic       prev_req = 1'b0;
    bit         fast_mode = 1'b0;
    int         cur_fr = 0;
    int         fr_k = 0;
    int         fr_target = 0;
    int         fr_ones = 0;
    int         fr_stuff [0:63];
    int         cnt = 0;
    logic [7:0] exp_bytes [0:1023];
    int         nexp = 0;
    int         exp_len [0:63];
    int         nclosed = 0;

    // decoder state
    logic [7:0] win = '0;
    int         w_cnt = 0;
    int         obs_n = 0;
    int         run = 0;
    int         d_ones = 0;
    logic       dbits [0:255];
    int         dq = 0;
    bit         in_sync = 1'b0;
    int         dec_fr = 0;
    int         dec_idx = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // returns {ones_out[3:0], stuffed_count[3:0]}
    function automatic logic [7:0] stuff_model(input logic [7:0] b, input int ones_in);
        int ones = ones_in;
        int s = 0;
        for (int i = 0; i < 8; i++) begin
            if (ones == 5) begin s++; ones = 0; end
            ones = b[i] ? ones + 1 : 0;
        end
        if (ones == 5) begin s++; ones = 0; end
        return {4'(ones), 4'(s)};
    endfunction

    function automatic logic [7:0] pick_byte(input int f, input int k);
        case (f)
            0: return 8'hFF;
            1: return k[0] ? 8'h1F : 8'hF8;
            2: return 8'h7E;
            3: return 8'h00;
            4: return 8'hBE;
            default: return ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
        endcase
    endfunction

    task automatic close_frame_check();
        int nbits = dq - 7;
        if (in_sync && nbits > 0) begin
            chk(nbits % 8 == 0, "R9 frame bit count multiple of 8", nbits, (nbits / 8) * 8);
            chk(dec_fr < nclosed && exp_len[dec_fr] == nbits / 8, "R9 frame byte count",
                nbits / 8, (dec_fr < nclosed) ? exp_len[dec_fr] : -1);
            for (int j = 0; j < nbits / 8; j++) begin
                logic [7:0] v;
                for (int i = 0; i < 8; i++) v[i] = dbits[j * 8 + i];
                chk(dec_idx < nexp && v == exp_bytes[dec_idx], "R4/R5/R6 decoded byte",
                    v, (dec_idx < nexp) ? exp_bytes[dec_idx] : 8'hxx);
                dec_idx++;
            end
            dec_fr++;
        end
    endtask

    task automatic take_bit(input logic b);
        // reset-time flag pattern, MSB first
        if (obs_n < 16) begin
            logic [7:0] fl = 8'h7E;
            chk(b == fl[7 - (obs_n % 8)], "R1 idle flag after reset", b, fl[7 - (obs_n % 8)]);
        end
        obs_n++;
        if (b) begin
            run++;
        end else begin
            chk(run <= 6, "R6 ones run length", run, 6);
            run = 0;
        end
        win = {win[6:0], b};
        w_cnt++;
        if (w_cnt >= 8 && win == 8'h7E) begin
            close_frame_check();
            in_sync = 1'b1;
            dq = 0;
            d_ones = 0;
        end else if (d_ones == 5 && !b) begin
            d_ones = 0;
        end else begin
            if (dq < 256) dbits[dq] = b;
            dq++;
            d_ones = b ? d_ones + 1 : 0;
        end
    endtask

    task automatic on_demand();
        logic [7:0] v;
        logic [7:0] sm;
        chk(send_msg == 1'b1, "R2 demand only with send_msg high", 0, 1);
        chk(prev_req == 1'b0, "R8 single-cycle demand", 1, 0);
        if (fr_k == 1) begin
            chk(cnt == 8, "R3/R7 opening flag spacing", cnt, 8);
        end else if (fr_k >= 2) begin
            chk(cnt == 8 + fr_stuff[fr_k - 2], "R7 demand spacing", cnt, 8 + fr_stuff[fr_k - 2]);
        end
        v = pick_byte(cur_fr, fr_k);
        sm = stuff_model(v, fr_ones);
        fr_stuff[fr_k] = int'(sm[3:0]);
        fr_ones = int'(sm[7:4]);
        exp_bytes[nexp] = v;
        nexp++;
        pay_byte = v;
        fr_k++;
        cnt = 0;
        if (fr_k == fr_target) begin
            send_msg = 1'b0;
            exp_len[nclosed] = fr_k;
            nclosed++;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (be_drv) begin
            take_bit(line_bit);
            cnt++;
        end
        if (byte_req) begin
            on_demand();
        end else if (be_drv && cnt == HALF) begin
            pay_byte = 8'($urandom);  // bus no longer valid after the capture point
        end
        prev_req = byte_req;
        be_drv = fast_mode ? 1'b1 : ($urandom_range(0, 2) != 0);
        bit_en = be_drv;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240607);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(line_bit == 1'b0, "R1 reset line_bit", line_bit, 0);
        chk(byte_req == 1'b0, "R1 reset byte_req", byte_req, 0);
        rst_n = 1'b1;
        // idle period: only flags, no demand with send_msg low
        for (int i = 0; i < 60; i++) begin
            tick();
            chk(byte_req == 1'b0, "R2 no demand while idle", byte_req, 0);
        end
        for (int f = 0; f < NFR; f++) begin
            int guard;
            cur_fr = f;
            fast_mode = (f % 4 == 3);
            fr_k = 0;
            fr_ones = 0;
            fr_target = (f < 5) ? 4 : (f == 5) ? 1 : int'($urandom_range(1, 12));
            send_msg = 1'b1;
            guard = 0;
            while (send_msg && guard < 4000) begin tick(); guard++; end
            guard = 0;
            while (dec_fr < f + 1 && guard < 4000) begin tick(); guard++; end
            chk(dec_fr == f + 1, "R9 frame closed", dec_fr, f + 1);
            for (int i = 0; i < int'($urandom_range(0, 20)); i++) tick();
        end
        for (int i = 0; i < 40; i++) begin
            tick();
            chk(byte_req == 1'b0, "R2 no demand after last frame", byte_req, 0);
        end
        chk(dec_idx == nexp, "R4 all demanded bytes decoded", dec_idx, nexp);
        chk(dec_fr == NFR, "R9 frame total", dec_fr, NFR);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected under %0d", LIMIT, LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule